// File: doc/BRIEF.md
# Filtered Receive Message Buffer

This block sits behind a bus protocol controller and takes one received frame per clock: a frame identifier, a cycle number and a payload of four data words. Filters in hardware decide whether each frame is kept and where it goes, so software never sees traffic it did not ask for.

There are two kinds of storage.

- **Dedicated slots** suit periodic state messages. Each slot has a filter on an exact identifier and a cycle pattern (base value plus repetition mask). A slot holds only the newest matching frame.
- **A shared FIFO** suits event messages, where every frame has to reach software. A frame that no slot claims is checked against an identifier range. If it falls inside, it is queued in arrival order.

The host sets the filters through a simple write port. It fetches slot contents or pops FIFO entries through one read port. Status outputs show, per slot, whether unread data is waiting and whether unread data was overwritten. They also give the FIFO fill level and a FIFO overflow flag.

Top module: `rx_filter_msgbuf`

## Requirements
- R1: A slot filter matches a frame when the filter is enabled, the frame identifier equals the filter identifier, and (frame cycle AND mask) equals the base. A matching frame is stored in that slot, and new_data for that slot is high after the same clock edge.
- R2: A slot keeps only the newest frame written to it. A host read with rd_req=1 and rd_sel_fifo=0 returns the slot's identifier, cycle and data, with rd_valid=1, one cycle later.
- R3: A slot's new_data bit is set by a write to the slot. It is cleared by a host read of that slot, unless a write to the same slot happens in the same cycle.
- R4: overrun for a slot is set, and stays set until reset, when a frame is written to the slot while its new_data is high and the slot is not read in that cycle.
- R5: The frame goes to the FIFO when all of these hold: no slot matches, the range filter is enabled, and low <= identifier <= high. Pops (rd_req=1, rd_sel_fifo=1) return entries in arrival order one cycle later, and fifo_count gives the number held.
- R6: A frame bound for a full FIFO is discarded and stored entries stay unchanged. Fullness is judged before any pop in the same cycle. fifo_ovf is set and stays set until reset.
- R7: A frame that matches no slot and falls outside the range filter is discarded with no change to any output.
- R8: When several slot filters match one frame, only the lowest-numbered slot is written.
- R9: When a host read and a frame write hit the same slot in one cycle, the read returns the complete older frame. new_data stays high and overrun is not set.
- R10: After reset all filters are disabled, and rd_valid, new_data, overrun, fifo_count and fifo_ovf are all zero.
- R11: A pop on an empty FIFO gives rd_valid=0 in the next cycle and changes no state.
- R12: Configuration uses cfg_idx 0..NUM_BUF-1 to address a slot filter (fields cfg_id_a, cfg_base, cfg_mask, cfg_en) and cfg_idx NUM_BUF to address the range filter (low cfg_id_a, high cfg_id_b, cfg_en). A filter written with cfg_en=0 matches nothing. A write takes effect for frames in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Filter write strobe |
| cfg_idx | input | clog2(NUM_BUF+1) | Filter select: slots, then the range filter |
| cfg_en | input | 1 | Filter enable |
| cfg_id_a | input | 11 | Slot identifier, or range low bound |
| cfg_id_b | input | 11 | Range high bound |
| cfg_base | input | 6 | Slot cycle base |
| cfg_mask | input | 6 | Slot cycle repetition mask |
| fr_valid | input | 1 | Received frame present |
| fr_id | input | 11 | Frame identifier |
| fr_cycle | input | 6 | Frame cycle number |
| fr_data | input | 64 | Payload, four 16-bit words |
| rd_req | input | 1 | Host read request |
| rd_sel_fifo | input | 1 | 1: pop the FIFO, 0: read a slot |
| rd_idx | input | clog2(NUM_BUF) | Slot to read |
| rd_valid | output | 1 | Read result valid |
| rd_id | output | 11 | Read identifier |
| rd_cycle | output | 6 | Read cycle number |
| rd_data | output | 64 | Read payload |
| new_data | output | NUM_BUF | Unread data present, per slot |
| overrun | output | NUM_BUF | Sticky unread-overwrite flag, per slot |
| fifo_count | output | clog2(FIFO_DEPTH+1) | FIFO fill level |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench targets the cases listed below.

- **Read and write to one slot in the same cycle.** A design that reads after writing returns the new frame, or a mix of the two. A design that clears the flag after the write loses the unread marker.
- **Two filters matching one frame.** A wrong priority stores the frame twice or in the higher slot.
- **A FIFO that overflows and then drains.** A bad design overwrites the oldest entries or reorders them.
- **A pop on an empty FIFO.** A bad design raises a false rd_valid.

A behavioural reference model built from queues runs through directed steps and a long random phase. It is compared with every output on every clock.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

    localparam int ID_W   = 11;
    localparam int CYC_W  = 6;
    localparam int WORD_W = 16;
    localparam int WORDS  = 4;
    localparam int DATA_W = WORD_W * WORDS;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [CYC_W-1:0]  cyc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              en;
        logic [ID_W-1:0]   id;
        logic [CYC_W-1:0]  base;
        logic [CYC_W-1:0]  mask;
    } slot_flt_t;

    typedef struct packed {
        logic            en;
        logic [ID_W-1:0] lo;
        logic [ID_W-1:0] hi;
    } range_flt_t;

    function automatic logic cycle_hit(input logic [CYC_W-1:0] cyc,
                                       input logic [CYC_W-1:0] base,
                                       input logic [CYC_W-1:0] mask);
        return (cyc & mask) == base;
    endfunction

    function automatic logic id_in_range(input logic [ID_W-1:0] id,
                                         input range_flt_t r);
        return r.en && (id >= r.lo) && (id <= r.hi);
    endfunction

endpackage

// File: rtl/rxfb_filter.sv
module rxfb_filter
    import rxfb_pkg::*;
#(
    parameter int NUM_BUF = 8,
    parameter int CFG_IW  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_IW-1:0]  cfg_idx,
    input  logic               cfg_en,
    input  logic [ID_W-1:0]    cfg_id_a,
    input  logic [ID_W-1:0]    cfg_id_b,
    input  logic [CYC_W-1:0]   cfg_base,
    input  logic [CYC_W-1:0]   cfg_mask,
    input  logic [ID_W-1:0]    key_id,
    input  logic [CYC_W-1:0]   key_cyc,
    output logic [NUM_BUF-1:0] slot_hit,
    output logic               fifo_hit
);

    logic [NUM_BUF-1:0] raw_hit;
    range_flt_t         rng_q;

    // One filter register and comparator per slot
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        slot_flt_t flt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flt_q <= '0;
            end else if (cfg_we && (cfg_idx == CFG_IW'(g))) begin
                flt_q <= '{en: cfg_en, id: cfg_id_a, base: cfg_base, mask: cfg_mask};
            end
        end

        assign raw_hit[g] = flt_q.en && (flt_q.id == key_id)
                          && cycle_hit(key_cyc, flt_q.base, flt_q.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rng_q <= '0;
        end else if (cfg_we && (cfg_idx == CFG_IW'(NUM_BUF))) begin
            rng_q <= '{en: cfg_en, lo: cfg_id_a, hi: cfg_id_b};
        end
    end

    // Lowest set bit wins: isolate it with two's complement
    assign slot_hit = raw_hit & (~raw_hit + NUM_BUF'(1));
    assign fifo_hit = (raw_hit == '0) && id_in_range(key_id, rng_q);

endmodule

// File: rtl/rxfb_slots.sv
module rxfb_slots
    import rxfb_pkg::*;
#(
    parameter int NUM_BUF = 8,
    parameter int RD_IW   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BUF-1:0] wr_vec,
    input  frame_t             wr_frame,
    input  logic               rd_en,
    input  logic [RD_IW-1:0]   rd_idx,
    output frame_t             rd_frame,
    output logic [NUM_BUF-1:0] new_data,
    output logic [NUM_BUF-1:0] overrun
);

    frame_t slots [NUM_BUF];

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        frame_t slot_q;
        logic   nd_q;
        logic   ov_q;
        logic   rd_this;

        assign rd_this = rd_en && (rd_idx == RD_IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
                nd_q   <= 1'b0;
                ov_q   <= 1'b0;
            end else if (wr_vec[g]) begin
                slot_q <= wr_frame;
                nd_q   <= 1'b1;
                if (nd_q && !rd_this) begin
                    ov_q <= 1'b1;
                end
            end else if (rd_this) begin
                nd_q <= 1'b0;
            end
        end

        assign slots[g]    = slot_q;
        assign new_data[g] = nd_q;
        assign overrun[g]  = ov_q;
    end

    // Read sees the stored value before this edge's write
    assign rd_frame = slots[rd_idx];

endmodule

// File: rtl/rxfb_fifo.sv
module rxfb_fifo
    import rxfb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  frame_t           push_frame,
    input  logic             pop,
    output frame_t           head,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t         mem [DEPTH];
    logic [AW-1:0]  wp_q;
    logic [AW-1:0]  rp_q;
    logic           full;
    logic           accept;
    logic           take;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full   = (count == CNT_W'(DEPTH));
    assign accept = push && !full;
    assign take   = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wp_q] <= push_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) begin
                wp_q <= ptr_inc(wp_q);
            end
            if (take) begin
                rp_q <= ptr_inc(rp_q);
            end
            if (push && full) begin
                ovf <= 1'b1;
            end
            count <= count + CNT_W'(accept) - CNT_W'(take);
        end
    end

    assign head = mem[rp_q];

endmodule

// File: rtl/rx_filter_msgbuf.sv
module rx_filter_msgbuf
    import rxfb_pkg::*;
#(
    parameter int NUM_BUF    = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int CFG_IW    = $clog2(NUM_BUF + 1),
    localparam int RD_IW     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_IW-1:0]  cfg_idx,
    input  logic               cfg_en,
    input  logic [ID_W-1:0]    cfg_id_a,
    input  logic [ID_W-1:0]    cfg_id_b,
    input  logic [CYC_W-1:0]   cfg_base,
    input  logic [CYC_W-1:0]   cfg_mask,
    input  logic               fr_valid,
    input  logic [ID_W-1:0]    fr_id,
    input  logic [CYC_W-1:0]   fr_cycle,
    input  logic [DATA_W-1:0]  fr_data,
    input  logic               rd_req,
    input  logic               rd_sel_fifo,
    input  logic [RD_IW-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [ID_W-1:0]    rd_id,
    output logic [CYC_W-1:0]   rd_cycle,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_BUF-1:0] new_data,
    output logic [NUM_BUF-1:0] overrun,
    output logic [CNT_W-1:0]   fifo_count,
    output logic               fifo_ovf
);

    frame_t             in_frame;
    frame_t             slot_rd_frame;
    frame_t             fifo_head;
    frame_t             rd_q;
    logic [NUM_BUF-1:0] slot_hit;
    logic [NUM_BUF-1:0] wr_vec;
    logic               fifo_hit;
    logic               rd_slot;
    logic               rd_pop;
    logic               pop_ok;

    assign in_frame = '{id: fr_id, cyc: fr_cycle, data: fr_data};
    assign wr_vec   = fr_valid ? slot_hit : '0;
    assign rd_slot  = rd_req && !rd_sel_fifo;
    assign rd_pop   = rd_req && rd_sel_fifo;
    assign pop_ok   = rd_pop && (fifo_count != '0);

    rxfb_filter #(.NUM_BUF(NUM_BUF), .CFG_IW(CFG_IW)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_en   (cfg_en),
        .cfg_id_a (cfg_id_a),
        .cfg_id_b (cfg_id_b),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .key_id   (fr_id),
        .key_cyc  (fr_cycle),
        .slot_hit (slot_hit),
        .fifo_hit (fifo_hit)
    );

    rxfb_slots #(.NUM_BUF(NUM_BUF), .RD_IW(RD_IW)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_vec   (wr_vec),
        .wr_frame (in_frame),
        .rd_en    (rd_slot),
        .rd_idx   (rd_idx),
        .rd_frame (slot_rd_frame),
        .new_data (new_data),
        .overrun  (overrun)
    );

    rxfb_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (fr_valid && fifo_hit),
        .push_frame (in_frame),
        .pop        (rd_pop),
        .head       (fifo_head),
        .count      (fifo_count),
        .ovf        (fifo_ovf)
    );

    // Registered host read result
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_q     <= '0;
        end else begin
            rd_valid <= rd_slot || pop_ok;
            if (rd_slot) begin
                rd_q <= slot_rd_frame;
            end else if (pop_ok) begin
                rd_q <= fifo_head;
            end
        end
    end

    assign rd_id    = rd_q.id;
    assign rd_cycle = rd_q.cyc;
    assign rd_data  = rd_q.data;

endmodule

// File: rtl/rx_filter_msgbuf_chk.sv
module rx_filter_msgbuf_chk #(
    parameter int NUM_BUF    = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_req,
    input logic               rd_sel_fifo,
    input logic               rd_valid,
    input logic [NUM_BUF-1:0] new_data,
    input logic [NUM_BUF-1:0] overrun,
    input logic [NUM_BUF-1:0] wr_vec,
    input logic [CNT_W-1:0]   fifo_count,
    input logic               fifo_ovf
);

    // R1, R3: a slot write leaves its flag set
    a_r3_write_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_vec != '0) |=> ((new_data & $past(wr_vec)) == $past(wr_vec)));

    // R4: overrun bits never fall outside reset
    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun != '0) |=> ((overrun & $past(overrun)) == $past(overrun)));

    // R5: level moves by at most one per cycle
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        fifo_count != '0 || fifo_count == '0 |=>
        ((fifo_count <= $past(fifo_count) + 1'b1) && (fifo_count + 1'b1 >= $past(fifo_count))));

    // R6: level bounded, overflow sticky
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(FIFO_DEPTH));
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        fifo_ovf |=> fifo_ovf);

    // R8: at most one slot written
    a_r8_single_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_vec));

    // R10: reset clears status
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!rd_valid && fifo_count == '0 && new_data == '0 && overrun == '0 && !fifo_ovf));

    // R11: empty pop yields nothing
    a_r11_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_sel_fifo && fifo_count == '0) |=> !rd_valid);

endmodule

bind rx_filter_msgbuf rx_filter_msgbuf_chk #(
    .NUM_BUF    (NUM_BUF),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .rd_sel_fifo (rd_sel_fifo),
    .rd_valid    (rd_valid),
    .new_data    (new_data),
    .overrun     (overrun),
    .wr_vec      (wr_vec),
    .fifo_count  (fifo_count),
    .fifo_ovf    (fifo_ovf)
);

// File: tb/rx_filter_msgbuf_test.sv
module rx_filter_msgbuf_test;

    typedef struct packed {
        logic [10:0] id;
        logic [5:0]  cyc;
        logic [63:0] data;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [10:0] cfg_id_a = '0, cfg_id_b = '0;
    logic [5:0]  cfg_base = '0, cfg_mask = '0;
    logic        fr_valid = 1'b0;
    logic [10:0] fr_id = '0;
    logic [5:0]  fr_cycle = '0;
    logic [63:0] fr_data = '0;
    logic        rd_req = 1'b0, rd_sel_fifo = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic        rd_valid;
    logic [10:0] rd_id;
    logic [5:0]  rd_cycle;
    logic [63:0] rd_data;
    logic [7:0]  new_data, overrun;
    logic [3:0]  fifo_count;
    logic        fifo_ovf;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    rx_filter_msgbuf uut (.*);

    // Reference model state
    logic        f_en [8];
    logic [10:0] f_id [8];
    logic [5:0]  f_base [8], f_mask [8];
    logic        r_en;
    logic [10:0] r_lo, r_hi;
    ent_t        m_slot [8];
    logic [7:0]  m_new, m_ovr;
    logic        m_fovf;
    ent_t        q [$];
    logic        e_valid;
    ent_t        e_ent;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                f_en[i] = 0; f_id[i] = 0; f_base[i] = 0; f_mask[i] = 0; m_slot[i] = '0;
            end
            r_en = 0; r_lo = 0; r_hi = 0;
            m_new = 0; m_ovr = 0; m_fovf = 0; q.delete();
            e_valid = 0; e_ent = '0;
        end else begin
            int hit;
            int pre;
            logic rslot;
            rslot = rd_req && !rd_sel_fifo;
            pre = q.size();
            e_valid = 0;
            if (rd_req) begin
                if (rd_sel_fifo) begin
                    if (pre > 0) begin e_valid = 1; e_ent = q.pop_front(); end
                end else begin
                    e_valid = 1; e_ent = m_slot[rd_idx];
                end
            end
            hit = -1;
            if (fr_valid)
                for (int i = 7; i >= 0; i--)
                    if (f_en[i] && f_id[i] == fr_id && (fr_cycle & f_mask[i]) == f_base[i]) hit = i;
            if (hit >= 0 && m_new[hit] && !(rslot && int'(rd_idx) == hit)) m_ovr[hit] = 1;
            if (rslot) m_new[rd_idx] = 0;
            if (hit >= 0) begin
                m_slot[hit] = '{fr_id, fr_cycle, fr_data};
                m_new[hit] = 1;
            end else if (fr_valid && r_en && fr_id >= r_lo && fr_id <= r_hi) begin
                if (pre == 8) m_fovf = 1;
                else q.push_back('{fr_id, fr_cycle, fr_data});
            end
            if (cfg_we) begin
                if (cfg_idx < 8) begin
                    f_en[cfg_idx[2:0]] = cfg_en; f_id[cfg_idx[2:0]] = cfg_id_a;
                    f_base[cfg_idx[2:0]] = cfg_base; f_mask[cfg_idx[2:0]] = cfg_mask;
                end else if (cfg_idx == 8) begin
                    r_en = cfg_en; r_lo = cfg_id_a; r_hi = cfg_id_b;
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            chk(rd_valid == e_valid, "R2/R11 rd_valid", 64'(rd_valid), 64'(e_valid));
            if (e_valid) begin
                chk(rd_id == e_ent.id && rd_cycle == e_ent.cyc, "R5 rd_id/cycle",
                    64'({rd_id, rd_cycle}), 64'({e_ent.id, e_ent.cyc}));
                chk(rd_data == e_ent.data, "R2 rd_data", rd_data, e_ent.data);
            end
            chk(new_data == m_new, "R3 new_data", 64'(new_data), 64'(m_new));
            chk(overrun == m_ovr, "R4 overrun", 64'(overrun), 64'(m_ovr));
            chk(int'(fifo_count) == q.size(), "R6 fifo_count", 64'(fifo_count), 64'(q.size()));
            chk(fifo_ovf == m_fovf, "R6 fifo_ovf", 64'(fifo_ovf), 64'(m_fovf));
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic cfg(input int idx, input logic en, input logic [10:0] a, input logic [10:0] b,
                       input logic [5:0] base, input logic [5:0] mask);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_id_a = a; cfg_id_b = b;
        cfg_base = base; cfg_mask = mask;
        tick();
        cfg_we = 0;
    endtask

    task automatic send(input logic [10:0] id, input logic [5:0] cyc, input logic [63:0] d);
        fr_valid = 1; fr_id = id; fr_cycle = cyc; fr_data = d;
        tick();
        fr_valid = 0;
    endtask

    task automatic rd(input logic fifo, input logic [2:0] idx);
        rd_req = 1; rd_sel_fifo = fifo; rd_idx = idx;
        tick();
        rd_req = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R10 reset state
        chk(fifo_count == 0 && !fifo_ovf && !rd_valid, "R10 fifo/rd reset", 64'(fifo_count), 0);
        chk(new_data == 0 && overrun == 0, "R10 flags reset", 64'({new_data, overrun}), 0);

        cfg(0, 1, 11'h010, 0, 6'd1, 6'd3);
        cfg(1, 1, 11'h010, 0, 6'd0, 6'd0);
        cfg(2, 1, 11'h020, 0, 6'd0, 6'd0);
        cfg(8, 1, 11'h100, 11'h1FF, 0, 0);

        send(11'h010, 6'd5, 64'hD1);
        chk(new_data == 8'b001, "R8 lowest slot wins", 64'(new_data), 64'b001);
        send(11'h010, 6'd2, 64'hD2);
        chk(new_data == 8'b011, "R1 cycle mask routes to slot1", 64'(new_data), 64'b011);
        send(11'h010, 6'd6, 64'hD3);
        chk(overrun == 8'b010, "R4 overrun on unread overwrite", 64'(overrun), 64'b010);
        rd(0, 3'd1);
        chk(rd_valid && rd_data == 64'hD3, "R2 newest frame kept", rd_data, 64'hD3);
        chk(new_data == 8'b001, "R3 read clears flag", 64'(new_data), 64'b001);

        send(11'h050, 6'd0, 64'hD4);
        chk(fifo_count == 0 && new_data == 8'b001, "R7 unmatched dropped", 64'(fifo_count), 0);

        for (int k = 0; k < 11; k++) send(11'h100 + 11'(k), 6'(k), 64'hF00 + 64'(k));
        chk(fifo_count == 8 && fifo_ovf, "R6 full drops and flags", 64'(fifo_count), 8);
        for (int k = 0; k < 8; k++) begin
            rd(1, 0);
            chk(rd_valid && rd_id == 11'h100 + 11'(k), "R5 arrival order", 64'(rd_id), 64'(11'h100 + 11'(k)));
        end
        rd(1, 0);
        chk(!rd_valid && fifo_count == 0, "R11 empty pop", 64'(rd_valid), 0);

        send(11'h020, 6'd0, 64'hAAAA);
        fr_valid = 1; fr_id = 11'h020; fr_cycle = 0; fr_data = 64'hBBBB;
        rd_req = 1; rd_sel_fifo = 0; rd_idx = 3'd2;
        tick();
        fr_valid = 0; rd_req = 0;
        chk(rd_data == 64'hAAAA, "R9 old snapshot", rd_data, 64'hAAAA);
        chk(new_data[2] && !overrun[2], "R9 flag kept, no overrun", 64'({new_data[2], overrun[2]}), 64'b10);
        rd(0, 3'd2);
        chk(rd_data == 64'hBBBB, "R9 new frame after", rd_data, 64'hBBBB);

        cfg(2, 0, 11'h020, 0, 0, 0);
        send(11'h020, 6'd0, 64'hCCCC);
        chk(new_data[2] == 0 && fifo_count == 0, "R12 disabled filter", 64'(new_data), 64'b001);
        rd(0, 3'd2);
        chk(rd_data == 64'hBBBB, "R12 slot untouched", rd_data, 64'hBBBB);

        // Random phase, model compared each cycle
        for (int n = 0; n < 3000; n++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            fr_valid = ($urandom_range(0, 3) != 0);
            fr_id = (sel < 3) ? 11'h010 : (sel < 5) ? 11'h020 : (sel < 8) ? 11'h100 + 11'($urandom_range(0, 15))
                  : (sel == 8) ? 11'h050 : 11'h030;
            fr_cycle = 6'($urandom_range(0, 63));
            fr_data = {$urandom, $urandom};
            rd_req = ($urandom_range(0, 2) == 0);
            rd_sel_fifo = $urandom_range(0, 1) != 0;
            rd_idx = 3'($urandom_range(0, 7));
            cfg_we = ($urandom_range(0, 99) == 0);
            cfg_idx = 4'(sel % 4); cfg_en = $urandom_range(0, 1) != 0;
            cfg_id_a = (sel % 2 == 0) ? 11'h020 : 11'h030; cfg_id_b = 11'h1FF;
            cfg_base = 0; cfg_mask = 6'($urandom_range(0, 1));
            tick();
        end
        fr_valid = 0; rd_req = 0; cfg_we = 0;
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule